// File: doc/BRIEF.md
# Masked Burst Address Counter

This block is the address front end of one port of a multi-port memory. On every clock edge it decides which address the memory array sees next: either the address presented on the port's address pins, or a value produced by an internal burst counter. The counter can be loaded, cleared or stepped. A mask register decides which low-order address bits take part in counting, so a burst can wrap inside a power-of-two window as well as across the whole address space.

Software or a controller can also ask to see the current counter or mask value. After such a request the port spends one idle cycle in which nothing is driven. On the next edge the requested value appears, together with a valid strobe.

An active-low master reset acts at once, without waiting for a clock edge. It brings the counter and the mask to known values.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and at once when it falls, the counter is 0, every mask bit is 1, `mem_addr` is 0, and `rb_valid` and `rb_idle` are 0.
- R2: When `cnt_ld` is the winning strobe at an edge, the counter takes `addr_in`. From that edge on, `mem_addr` shows the loaded value.
- R3: When `cnt_inc` is the winning strobe at an edge, every counter bit whose mask bit is 1 takes the value of (counter + 1), and every bit whose mask bit is 0 keeps its value. `mem_addr` then shows the new counter value.
- R4: With a mask of k low-order ones, repeated increments run through the 2^k values of the window and go back to the window base once the unmasked bits are all ones. With an all-ones mask the counter wraps from the top address to 0.
- R5: When `cnt_rst` is high at an edge, the counter becomes 0 and the mask keeps its value.
- R6: When `mask_ld` is the winning strobe at an edge, the mask takes `addr_in` and the counter keeps its value.
- R7: The strobes are ranked from highest to lowest as `cnt_rst`, `mask_ld`, `cnt_ld`, `cnt_inc`. Only the highest one asserted at an edge takes effect. With none asserted, the counter holds.
- R8: At an edge where neither a load nor an increment wins, `mem_addr` takes `addr_in` as sampled at that edge.
- R9: When `rd_cnt` or `rd_mask` is high at an edge, `rb_idle` is 1 during the following cycle.
- R10: One edge after the idle cycle, `rb_valid` is 1 for one cycle and `rb_data` holds the counter value if `rd_cnt` was high, and the mask value only if `rd_cnt` was low. The value returned is the state held during the idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low master reset |
| cnt_rst | input | 1 | Clear the burst counter |
| mask_ld | input | 1 | Write `addr_in` into the mask register |
| cnt_ld | input | 1 | Write `addr_in` into the burst counter |
| cnt_inc | input | 1 | Advance the burst counter by one |
| rd_cnt | input | 1 | Request readback of the counter |
| rd_mask | input | 1 | Request readback of the mask |
| addr_in | input | ADDR_W | External address, also the source for loads |
| mem_addr | output | ADDR_W | Effective address presented to the memory array |
| rb_idle | output | 1 | Idle cycle after a readback request, bus not driven |
| rb_valid | output | 1 | Readback value present on `rb_data` |
| rb_data | output | ADDR_W | Returned counter or mask value |

## Verification
The bench runs a 6-bit instance. For every contiguous low-order mask width it loads several start values and increments past a full wrap, which catches a counter that runs into masked bits or fails to return to the window base. It drives all sixteen combinations of the four operation strobes with changing addresses, so a swapped priority would corrupt the counter or mask that the later readbacks show. Readback requests with both selects, one select, and back-to-back requests check for a missing idle cycle, a value delivered one edge off, or the mask winning over the counter. A master reset dropped in mid-cycle shows whether the clear really waits for no clock.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
   typedef enum logic [2:0] {
      OP_HOLD = 3'd0,
      OP_CRST = 3'd1,
      OP_MLD  = 3'd2,
      OP_LD   = 3'd3,
      OP_INC  = 3'd4
   } cnt_op_e;
endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
   import burst_addr_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cnt_rst,
   input  logic    mask_ld,
   input  logic    cnt_ld,
   input  logic    cnt_inc,
   output cnt_op_e op
);
   always_comb begin
      if (cnt_rst)      op = OP_CRST;
      else if (mask_ld) op = OP_MLD;
      else if (cnt_ld)  op = OP_LD;
      else if (cnt_inc) op = OP_INC;
      else              op = OP_HOLD;
   end

   // R7: a mask load under a counter clear is shadowed
   p_crst_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rst && mask_ld) |-> op == OP_CRST);
   p_mld_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_ld && !cnt_rst && (cnt_ld || cnt_inc)) |-> op == OP_MLD);
   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cnt_rst || mask_ld || cnt_ld || cnt_inc) |-> op == OP_HOLD);
endmodule

// File: rtl/burst_counter.sv
module burst_counter
   import burst_addr_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cnt_op_e           op,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] cnt_q,
   output logic [ADDR_W-1:0] mask_q,
   output logic [ADDR_W-1:0] cnt_nxt
);
   localparam logic [ADDR_W-1:0] MASK_RST = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] stepped;
   logic [ADDR_W-1:0] mask_nxt;

   assign sum = cnt_q + ONE;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      assign stepped[i] = mask_q[i] ? sum[i] : cnt_q[i];
   end

   always_comb begin
      cnt_nxt  = cnt_q;
      mask_nxt = mask_q;
      unique case (op)
         OP_CRST: cnt_nxt  = '0;
         OP_MLD:  mask_nxt = addr_in;
         OP_LD:   cnt_nxt  = addr_in;
         OP_INC:  cnt_nxt  = stepped;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         mask_q <= MASK_RST;
      end else begin
         cnt_q  <= cnt_nxt;
         mask_q <= mask_nxt;
      end
   end

   p_ld_r2: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_LD |=> cnt_q == $past(addr_in));
   p_masked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_INC |=> ((cnt_q ^ $past(cnt_q)) & ~$past(mask_q)) == '0);
   p_crst_keeps_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_CRST |=> (cnt_q == '0) && $stable(mask_q));
   p_mld_keeps_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_MLD |=> (mask_q == $past(addr_in)) && $stable(cnt_q));
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_HOLD |=> $stable(cnt_q) && $stable(mask_q));
endmodule

// File: rtl/burst_readback.sv
module burst_readback #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_cnt,
   input  logic              rd_mask,
   input  logic [ADDR_W-1:0] cnt_q,
   input  logic [ADDR_W-1:0] mask_q,
   output logic              rb_idle,
   output logic              rb_valid,
   output logic [ADDR_W-1:0] rb_data
);
   logic pend_q;
   logic pend_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         pend_cnt_q <= 1'b0;
         rb_valid   <= 1'b0;
         rb_data    <= '0;
      end else begin
         pend_q     <= rd_cnt | rd_mask;
         pend_cnt_q <= rd_cnt;
         rb_valid   <= pend_q;
         if (pend_q) rb_data <= pend_cnt_q ? cnt_q : mask_q;
      end
   end

   assign rb_idle = pend_q;

   p_idle_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cnt || rd_mask) |=> rb_idle);
   p_valid_after_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rb_idle |=> rb_valid);
   p_cnt_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_idle && pend_cnt_q) |=> rb_data == $past(cnt_q));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_addr_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_rst,
   input  logic              mask_ld,
   input  logic              cnt_ld,
   input  logic              cnt_inc,
   input  logic              rd_cnt,
   input  logic              rd_mask,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              rb_idle,
   output logic              rb_valid,
   output logic [ADDR_W-1:0] rb_data
);
   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_width
      $error("burst_addr_gen: ADDR_W must lie in 2..64");
   end

   cnt_op_e           op;
   logic [ADDR_W-1:0] cnt_q;
   logic [ADDR_W-1:0] mask_q;
   logic [ADDR_W-1:0] cnt_nxt;
   logic              use_cnt;

   burst_op_decode u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_rst (cnt_rst),
      .mask_ld (mask_ld),
      .cnt_ld  (cnt_ld),
      .cnt_inc (cnt_inc),
      .op      (op)
   );

   burst_counter #(.ADDR_W(ADDR_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .addr_in (addr_in),
      .cnt_q   (cnt_q),
      .mask_q  (mask_q),
      .cnt_nxt (cnt_nxt)
   );

   burst_readback #(.ADDR_W(ADDR_W)) u_rb (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_cnt   (rd_cnt),
      .rd_mask  (rd_mask),
      .cnt_q    (cnt_q),
      .mask_q   (mask_q),
      .rb_idle  (rb_idle),
      .rb_valid (rb_valid),
      .rb_data  (rb_data)
   );

   assign use_cnt = (op == OP_LD) || (op == OP_INC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_addr <= '0;
      else        mem_addr <= use_cnt ? cnt_nxt : addr_in;
   end

   p_follow_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      use_cnt |=> mem_addr == cnt_q);
   p_follow_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !use_cnt |=> mem_addr == $past(addr_in));
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
   localparam int W = 6;
   localparam int PERIOD = 10;
   localparam logic [W-1:0] ALL1 = {W{1'b1}};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnt_rst = 0, mask_ld = 0, cnt_ld = 0, cnt_inc = 0;
   logic         rd_cnt = 0, rd_mask = 0;
   logic [W-1:0] addr_in = '0;
   logic [W-1:0] mem_addr, rb_data;
   logic         rb_idle, rb_valid;

   int errors = 0;
   int checks = 0;

   // bench model state
   logic [W-1:0] m_cnt, m_mask, e_addr, e_rbd;
   logic         e_idle, e_rbv, m_pend, m_pend_cnt;

   always #(PERIOD/2) clk = ~clk;

   burst_addr_gen #(.ADDR_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .mask_ld(mask_ld),
      .cnt_ld(cnt_ld), .cnt_inc(cnt_inc), .rd_cnt(rd_cnt), .rd_mask(rd_mask),
      .addr_in(addr_in), .mem_addr(mem_addr), .rb_idle(rb_idle),
      .rb_valid(rb_valid), .rb_data(rb_data)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_cnt = '0; m_mask = ALL1; e_addr = '0; e_rbd = '0;
      e_idle = 0; e_rbv = 0; m_pend = 0; m_pend_cnt = 0;
   endtask

   // one clock with the given strobes; model follows the requirements
   task automatic step(input logic cr, input logic ml, input logic ld, input logic inc,
                       input logic rc, input logic rm, input logic [W-1:0] a);
      logic [W-1:0] stp;
      string tag;
      cnt_rst = cr; mask_ld = ml; cnt_ld = ld; cnt_inc = inc;
      rd_cnt = rc; rd_mask = rm; addr_in = a;
      @(posedge clk);
      // R10: value returned is state held during the idle cycle
      if (m_pend) e_rbd = m_pend_cnt ? m_cnt : m_mask;
      e_rbv = m_pend;
      e_idle = rc | rm;
      m_pend = rc | rm;
      m_pend_cnt = rc;
      stp = m_cnt + 1'b1;
      tag = "R8";
      if (cr) m_cnt = '0;                                   // R5, R7
      else if (ml) m_mask = a;                              // R6, R7
      else if (ld) begin m_cnt = a; tag = "R2"; end          // R2
      else if (inc) begin                                    // R3, R4
         m_cnt = (m_cnt & ~m_mask) | (stp & m_mask); tag = "R3";
      end
      e_addr = (tag == "R8") ? a : m_cnt;
      @(negedge clk);
      chk(tag, mem_addr, e_addr);
      chk("R9", {{(W-1){1'b0}}, rb_idle}, {{(W-1){1'b0}}, e_idle});
      chk("R10", {{(W-1){1'b0}}, rb_valid}, {{(W-1){1'b0}}, e_rbv});
      if (e_rbv) chk("R10", rb_data, e_rbd);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, W'(i * 7));
   endtask

   initial begin
      #(PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state at the ports
      chk("R1", mem_addr, '0);
      chk("R1", {{(W-1){1'b0}}, rb_valid | rb_idle}, '0);
      rst_n = 1'b1;
      // R1, R10: counter 0 and mask all ones, counter wins when both asked
      step(0, 0, 0, 0, 1, 1, '0);
      idle(2);
      chk("R1", rb_data, '0);
      step(0, 0, 0, 0, 0, 1, '0);
      idle(2);
      chk("R1", rb_data, ALL1);

      // R3, R4: sweep every contiguous low mask and several bases
      for (int k = 0; k <= W; k++) begin
         for (int s = 0; s < 4; s++) begin
            logic [W-1:0] msk, base;
            msk = W'((1 << k) - 1);
            base = W'(s * 23 + 5);
            step(0, 1, 0, 0, 0, 0, msk);
            step(0, 0, 1, 0, 0, 0, base);
            for (int n = 0; n < (1 << k) + 3; n++) step(0, 0, 0, 1, 0, 0, W'(n));
            // R4: count wrapped back to the window start plus remainder
            step(0, 0, 0, 0, 1, 0, '0);
            idle(2);
            chk("R4", rb_data,
                (base & ~msk) | W'((int'(base & msk) + (1 << k) + 3) % (1 << k == 0 ? 1 : (1 << k))));
         end
      end

      // R4: full mask wraps top address to zero
      step(0, 1, 0, 0, 0, 0, ALL1);
      step(0, 0, 1, 0, 0, 0, ALL1);
      step(0, 0, 0, 1, 0, 0, '0);
      chk("R4", mem_addr, '0);

      // R7, R5, R6: every strobe combination, state read back after each
      for (int c = 0; c < 16; c++) begin
         step(0, 1, 0, 0, 0, 0, 6'h0F);
         step(0, 0, 1, 0, 0, 0, 6'h2D);
         step(c[3], c[2], c[1], c[0], 0, 0, W'(c * 3 + 17));
         step(0, 0, 0, 0, 1, 0, W'(c));
         step(0, 0, 0, 0, 0, 1, W'(c + 1));
         step(0, 0, 0, 0, 0, 0, '0);
         step(0, 0, 0, 0, 0, 0, '0);
      end

      // R5: counter reset keeps the mask
      step(0, 1, 0, 0, 0, 0, 6'h07);
      step(0, 0, 1, 0, 0, 0, 6'h3B);
      step(1, 0, 0, 0, 0, 1, 6'h11);
      idle(2);
      chk("R5", rb_data, 6'h07);

      // R9, R10: back-to-back alternating readbacks during counting
      for (int i = 0; i < 8; i++) step(0, 0, 0, 1, i[0], ~i[0], W'(i));
      idle(3);

      // R8: external address flows with no load or increment
      for (int i = 0; i < 64; i++) step(0, 0, 0, 0, 0, 0, W'(i ^ 6'h15));

      // R1: asynchronous master reset in mid-cycle
      step(0, 0, 1, 0, 1, 0, 6'h2A);
      #1 rst_n = 1'b0;
      #1;
      chk("R1", mem_addr, '0);
      chk("R1", {{(W-1){1'b0}}, rb_valid | rb_idle}, '0);
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, 0, 0, 1, 0, '0);
      idle(2);
      chk("R1", rb_data, '0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule